// File: doc/BRIEF.md
# Compressed VLIW Instruction Length Decoder

This block works out the byte layout of each instruction in a compressed stream for a five-slot VLIW core. Each issue slot carries a 2-bit code that gives its operation one of three sizes: 26 bits with no extension, 34 bits with one extension byte, or 42 bits with two extension bytes. The code can also mark the slot as empty, in which case it takes no space. The codes for an instruction travel in the instruction before it. The decoder therefore keeps the 10-bit field from each accepted beat and uses it to lay out the following beat.

For each accepted beat, the decoder reports:
- the total instruction length in bytes;
- how many operations are present, and which slots they occupy;
- the size in bits of each slot's operation;
- each slot's extension byte count;
- the byte offset of each operation's 24-bit main part;
- the byte offset of each operation's extension bytes.

A beat flagged as a branch target is uncompressed. Its layout is always five 42-bit operations, 28 bytes in all, whatever field was held from the beat before. A single upstream producer feeds one beat per instruction over a valid/ready handshake. The result for each beat comes out of a register one cycle after the beat is accepted, and is held until the consumer takes it.

Top module: `vliw_len_decoder`

## Requirements
- R1: While reset is asserted and for two cycles after it is released, `out_valid` is 0 and `in_ready` is 0. After that, `in_ready` is 1 while no result is pending.
- R2: Slot i is coded by field bits [2i+1:2i], read as {msb,lsb}. The codes decode as follows:
  - 2'b00: 26-bit operation, 0 extension bytes.
  - 2'b01: 34-bit operation, 1 extension byte.
  - 2'b10: 42-bit operation, 2 extension bytes.
  - 2'b11: empty slot.
  Slot i's size in bits appears in `out_size[6i+5:6i]`, and its extension count appears in `out_ext[2i+1:2i]`.
- R3: The result for an accepted beat is laid out from the field of the previously accepted beat. The first beat after reset is laid out as all slots empty, which gives length 2 and 0 operations.
- R4: The length is 2 + 3n + (1 if n > 3) + (total extension bytes), where n is the number of operations present.
- R5: The operation of rank r, counting present slots from slot 0 upward, has its main part at byte offset 2 + 3r + (1 if r ≥ 3). The offset appears in `out_op_off[5i+4:5i]` for its slot i.
- R6: Extension bytes follow all main parts, in slot order. The first extension byte of each operation that has one sits at the running offset in `out_ext_off[5i+4:5i]`, and this offset is 0 for an operation with no extension.
- R7: A beat with `in_brtgt` = 1 is laid out as five 42-bit operations with length 28, and the held field is ignored. The field that arrives with the branch-target beat is still kept for the next beat.
- R8: `out_nops` equals the number of set bits in `out_used`, and `out_used[i]` is 1 exactly for the present slots.
- R9: While `out_valid` = 1 and `out_ready` = 0, all outputs hold steady and `in_ready` is 0. Results leave in the order their beats were accepted.
- R10: An empty slot reports 0 for its size, its extension count and both of its offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Beat offered |
| in_ready | output | 1 | Beat can be accepted |
| in_fmt | input | 10 | Slot codes carried by this beat, which describe the next beat |
| in_brtgt | input | 1 | This beat is an uncompressed branch target |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_len | output | 5 | Instruction length in bytes |
| out_nops | output | 3 | Number of operations present |
| out_used | output | 5 | Per-slot presence mask |
| out_size | output | 30 | Per-slot operation size in bits, 6 bits per slot |
| out_ext | output | 10 | Per-slot extension byte count, 2 bits per slot |
| out_op_off | output | 25 | Per-slot main-part byte offset, 5 bits per slot |
| out_ext_off | output | 25 | Per-slot first extension byte offset, 5 bits per slot |

## Verification
The assertions check the following on every cycle:
- the length stays within its bounds;
- the operation count agrees with the presence mask;
- empty slots report zeros;
- a branch-target beat yields the 28-byte, five-operation layout;
- a stalled result holds steady while the input is blocked.

Only the bench's scenarios can show the rest:
- the one-beat delay of the slot field, including the all-empty layout after reset;
- the exact offsets of the main parts across the extra byte after the third operation;
- the running extension offsets;
- that a branch-target beat still passes its own field on to the next beat.

// File: rtl/vlen_pkg.sv
package vlen_pkg;

  // Slot code, read as {msb, lsb} of the 2-bit field.
  typedef enum logic [1:0] {
    SLOT_OP26  = 2'b00,
    SLOT_OP34  = 2'b01,
    SLOT_OP42  = 2'b10,
    SLOT_EMPTY = 2'b11
  } slot_code_e;

  localparam int unsigned BASE_OP_BITS = 26;
  localparam int unsigned EXT_BYTE_BITS = 8;

  // Extension bytes implied by a slot code.
  function automatic logic [1:0] code_ext(input logic [1:0] code);
    logic [1:0] r;
    case (slot_code_e'(code))
      SLOT_OP34: r = 2'd1;
      SLOT_OP42: r = 2'd2;
      default:   r = 2'd0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/vlen_slot_classify.sv
module vlen_slot_classify
  import vlen_pkg::*;
#(
  parameter int NSLOT  = 5,
  parameter int SIZE_W = 6
) (
  input  logic [2*NSLOT-1:0]      fmt,
  output logic [NSLOT-1:0]        used,
  output logic [NSLOT*SIZE_W-1:0] size_bits,
  output logic [2*NSLOT-1:0]      ext_cnt
);

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic [1:0] code;
    logic       present;
    logic [1:0] ext;

    assign code    = fmt[2*g +: 2];
    assign present = (code != SLOT_EMPTY);
    assign ext     = code_ext(code);

    assign used[g]                     = present;
    assign ext_cnt[2*g +: 2]           = ext;
    assign size_bits[SIZE_W*g +: SIZE_W] =
      present ? SIZE_W'(BASE_OP_BITS + EXT_BYTE_BITS * int'(ext)) : '0;
  end

endmodule

// File: rtl/vlen_layout_accum.sv
module vlen_layout_accum #(
  parameter int NSLOT      = 5,
  parameter int HDR_BYTES  = 2,
  parameter int MAIN_BYTES = 3,
  parameter int GROUP      = 3,
  parameter int OFF_W      = 5,
  parameter int CNT_W      = 3
) (
  input  logic [NSLOT-1:0]       used,
  input  logic [2*NSLOT-1:0]     ext_cnt,
  output logic [NSLOT*OFF_W-1:0] op_off,
  output logic [NSLOT*OFF_W-1:0] ext_off,
  output logic [CNT_W-1:0]       nops,
  output logic [OFF_W-1:0]       len
);

  always_comb begin
    int rank;
    int acc;
    op_off  = '0;
    ext_off = '0;
    rank    = 0;
    // Main parts in slot order; one extra field byte ahead of the second group.
    for (int i = 0; i < NSLOT; i++) begin
      if (used[i]) begin
        op_off[i*OFF_W +: OFF_W] =
          OFF_W'(HDR_BYTES + MAIN_BYTES * rank + ((rank >= GROUP) ? 1 : 0));
        rank = rank + 1;
      end
    end
    acc = HDR_BYTES + MAIN_BYTES * rank + ((rank > GROUP) ? 1 : 0);
    // Extension bytes trail every main part, again in slot order.
    for (int i = 0; i < NSLOT; i++) begin
      if (used[i] && (ext_cnt[2*i +: 2] != 2'd0)) begin
        ext_off[i*OFF_W +: OFF_W] = OFF_W'(acc);
        acc = acc + int'(ext_cnt[2*i +: 2]);
      end
    end
    nops = CNT_W'(rank);
    len  = OFF_W'(acc);
  end

endmodule

// File: rtl/vliw_len_decoder.sv
module vliw_len_decoder #(
  parameter int NSLOT      = 5,
  parameter int HDR_BYTES  = 2,
  parameter int MAIN_BYTES = 3,
  parameter int GROUP      = 3,
  localparam int FMT_W     = 2 * NSLOT,
  localparam int MAX_LEN   = HDR_BYTES + MAIN_BYTES * NSLOT
                             + ((NSLOT > GROUP) ? 1 : 0) + 2 * NSLOT,
  localparam int LEN_W     = $clog2(MAX_LEN + 1),
  localparam int CNT_W     = $clog2(NSLOT + 1),
  localparam int SIZE_W    = $clog2(vlen_pkg::BASE_OP_BITS
                                    + 2 * vlen_pkg::EXT_BYTE_BITS + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [FMT_W-1:0]        in_fmt,
  input  logic                    in_brtgt,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [LEN_W-1:0]        out_len,
  output logic [CNT_W-1:0]        out_nops,
  output logic [NSLOT-1:0]        out_used,
  output logic [NSLOT*SIZE_W-1:0] out_size,
  output logic [FMT_W-1:0]        out_ext,
  output logic [NSLOT*LEN_W-1:0]  out_op_off,
  output logic [NSLOT*LEN_W-1:0]  out_ext_off
);

  localparam logic [FMT_W-1:0] FMT_BRANCH = {NSLOT{2'b10}};
  localparam logic [FMT_W-1:0] FMT_IDLE   = {FMT_W{1'b1}};

  // Reset release synchroniser
  logic [1:0] rs_q, rs_d;
  logic       run;

  assign rs_d = {rs_q[0], 1'b1};
  assign run  = rs_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= rs_d;
  end

  // Handshake and field carry
  logic             accept;
  logic             valid_q, valid_d;
  logic [FMT_W-1:0] held_q, held_d, eff_fmt;

  assign in_ready = run && (!valid_q || out_ready);
  assign accept   = in_valid && in_ready;
  assign held_d   = accept ? in_fmt : held_q;
  assign valid_d  = accept ? 1'b1 : (out_ready ? 1'b0 : valid_q);
  assign eff_fmt  = in_brtgt ? FMT_BRANCH : held_q;

  // Layout datapath
  logic [NSLOT-1:0]        c_used;
  logic [NSLOT*SIZE_W-1:0] c_size;
  logic [FMT_W-1:0]        c_ext;
  logic [NSLOT*LEN_W-1:0]  c_op_off, c_ext_off;
  logic [CNT_W-1:0]        c_nops;
  logic [LEN_W-1:0]        c_len;

  vlen_slot_classify #(
    .NSLOT  (NSLOT),
    .SIZE_W (SIZE_W)
  ) u_classify (
    .fmt       (eff_fmt),
    .used      (c_used),
    .size_bits (c_size),
    .ext_cnt   (c_ext)
  );

  vlen_layout_accum #(
    .NSLOT      (NSLOT),
    .HDR_BYTES  (HDR_BYTES),
    .MAIN_BYTES (MAIN_BYTES),
    .GROUP      (GROUP),
    .OFF_W      (LEN_W),
    .CNT_W      (CNT_W)
  ) u_accum (
    .used    (c_used),
    .ext_cnt (c_ext),
    .op_off  (c_op_off),
    .ext_off (c_ext_off),
    .nops    (c_nops),
    .len     (c_len)
  );

  // Registers
  logic [LEN_W-1:0]        len_q;
  logic [CNT_W-1:0]        nops_q;
  logic [NSLOT-1:0]        used_q;
  logic [NSLOT*SIZE_W-1:0] size_q;
  logic [FMT_W-1:0]        ext_q;
  logic [NSLOT*LEN_W-1:0]  op_off_q, ext_off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      held_q  <= FMT_IDLE;
    end else begin
      valid_q <= valid_d;
      held_q  <= held_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q     <= '0;
      nops_q    <= '0;
      used_q    <= '0;
      size_q    <= '0;
      ext_q     <= '0;
      op_off_q  <= '0;
      ext_off_q <= '0;
    end else if (accept) begin
      len_q     <= c_len;
      nops_q    <= c_nops;
      used_q    <= c_used;
      size_q    <= c_size;
      ext_q     <= c_ext;
      op_off_q  <= c_op_off;
      ext_off_q <= c_ext_off;
    end
  end

  assign out_valid   = valid_q;
  assign out_len     = len_q;
  assign out_nops    = nops_q;
  assign out_used    = used_q;
  assign out_size    = size_q;
  assign out_ext     = ext_q;
  assign out_op_off  = op_off_q;
  assign out_ext_off = ext_off_q;

endmodule

// File: rtl/vliw_len_decoder_chk.sv
module vliw_len_decoder_chk #(
  parameter int NSLOT     = 5,
  parameter int HDR_BYTES = 2,
  parameter int MAX_LEN   = 28,
  parameter int LEN_W     = 5,
  parameter int CNT_W     = 3,
  parameter int SIZE_W    = 6
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    in_brtgt,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [LEN_W-1:0]        out_len,
  input logic [CNT_W-1:0]        out_nops,
  input logic [NSLOT-1:0]        out_used,
  input logic [NSLOT*SIZE_W-1:0] out_size,
  input logic [2*NSLOT-1:0]      out_ext,
  input logic [NSLOT*LEN_W-1:0]  out_op_off,
  input logic [NSLOT*LEN_W-1:0]  out_ext_off
);

  logic empties_clean;

  always_comb begin
    empties_clean = 1'b1;
    for (int i = 0; i < NSLOT; i++) begin
      if (!out_used[i] && ((out_size[i*SIZE_W +: SIZE_W] != '0)
                           || (out_ext[2*i +: 2] != '0)
                           || (out_op_off[i*LEN_W +: LEN_W] != '0)
                           || (out_ext_off[i*LEN_W +: LEN_W] != '0)))
        empties_clean = 1'b0;
    end
  end

  p_len_bounds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_len) >= HDR_BYTES) && (int'(out_len) <= MAX_LEN));

  p_count_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(out_used) == int'(out_nops)));

  p_empty_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> empties_clean);

  p_branch_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_brtgt) |=>
      (out_valid && (int'(out_len) == MAX_LEN) && (int'(out_nops) == NSLOT)));

  p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_len) && $stable(out_used)
       && $stable(out_op_off) && $stable(out_ext_off)));

  p_block_input_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

endmodule

bind vliw_len_decoder vliw_len_decoder_chk #(
  .NSLOT     (NSLOT),
  .HDR_BYTES (HDR_BYTES),
  .MAX_LEN   (MAX_LEN),
  .LEN_W     (LEN_W),
  .CNT_W     (CNT_W),
  .SIZE_W    (SIZE_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_brtgt    (in_brtgt),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_len     (out_len),
  .out_nops    (out_nops),
  .out_used    (out_used),
  .out_size    (out_size),
  .out_ext     (out_ext),
  .out_op_off  (out_op_off),
  .out_ext_off (out_ext_off)
);

// File: tb/tb_vliw_len_decoder.sv
module tb_vliw_len_decoder;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [9:0]  in_fmt;
  logic        in_brtgt;
  logic        out_valid;
  logic        out_ready;
  logic [4:0]  out_len;
  logic [2:0]  out_nops;
  logic [4:0]  out_used;
  logic [29:0] out_size;
  logic [9:0]  out_ext;
  logic [24:0] out_op_off;
  logic [24:0] out_ext_off;

  always #10 clk = ~clk;

  vliw_len_decoder dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_fmt(in_fmt), .in_brtgt(in_brtgt), .out_valid(out_valid),
    .out_ready(out_ready), .out_len(out_len), .out_nops(out_nops),
    .out_used(out_used), .out_size(out_size), .out_ext(out_ext),
    .out_op_off(out_op_off), .out_ext_off(out_ext_off)
  );

  typedef struct packed {
    logic [4:0]  len;
    logic [2:0]  nops;
    logic [4:0]  used;
    logic [29:0] size;
    logic [9:0]  ext;
    logic [24:0] op_off;
    logic [24:0] ext_off;
  } res_t;

  res_t  exp_q[$];
  string tag_q[$];
  int    n_checks = 0;
  int    n_fail   = 0;
  logic  stall_mode = 1'b0;
  logic  done = 1'b0;
  logic [9:0] mdl_fmt = 10'h3FF;

  // Layout model built from the requirements.
  function automatic res_t layout(input logic [9:0] f);
    res_t r;
    int   n;
    int   pos;
    r = '0;
    n = 0;
    for (int s = 0; s < 5; s++) begin
      logic [1:0] c;
      c = f[2*s +: 2];
      if (c != 2'b11) begin
        r.used[s] = 1'b1;
        r.ext[2*s +: 2] = c;
        r.size[6*s +: 6] = (c == 2'b00) ? 6'd26 : (c == 2'b01) ? 6'd34 : 6'd42;
        r.op_off[5*s +: 5] = 5'(2 + 3 * n + ((n >= 3) ? 1 : 0));
        n++;
      end
    end
    pos = 2 + 3 * n + ((n > 3) ? 1 : 0);
    for (int s = 0; s < 5; s++) begin
      if (r.used[s] && r.ext[2*s +: 2] != 2'd0) begin
        r.ext_off[5*s +: 5] = 5'(pos);
        pos += int'(r.ext[2*s +: 2]);
      end
    end
    r.nops = 3'(n);
    r.len  = 5'(pos);
    return r;
  endfunction

  function automatic logic [9:0] mk(input logic [1:0] s0, input logic [1:0] s1,
                                    input logic [1:0] s2, input logic [1:0] s3,
                                    input logic [1:0] s4);
    return {s4, s3, s2, s1, s0};
  endfunction

  task automatic check_bit(input string tag, input logic got, input logic exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  // Driver: offers one beat and records the expected result on acceptance.
  task automatic send(input logic [9:0] f, input logic br, input string tag);
    @(negedge clk);
    in_fmt   = f;
    in_brtgt = br;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    exp_q.push_back(layout(br ? 10'h2AA : mdl_fmt));
    tag_q.push_back(tag);
    mdl_fmt = f;
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  // Consumer ready pattern, changed away from both edges.
  initial begin
    out_ready = 1'b1;
    forever begin
      @(posedge clk);
      #5 out_ready = stall_mode ? (($urandom % 3) != 0) : 1'b1;
    end
  end

  // Monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_valid) begin
        res_t got;
        got = {out_len, out_nops, out_used, out_size, out_ext, out_op_off, out_ext_off};
        n_checks++;
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL R9 unexpected result: got %h expected none", got);
        end else begin
          if (got !== exp_q[0]) begin
            n_fail++;
            $display("FAIL %s%s: got %h expected %h", tag_q[0],
                     out_ready ? "" : " (R9 held)", got, exp_q[0]);
          end
          if (out_ready) begin
            void'(exp_q.pop_front());
            void'(tag_q.pop_front());
          end
        end
      end
    end
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  // Watchdog
  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [9:0] rf;
    logic       rb;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_fmt   = '0;
    in_brtgt = 1'b0;
    repeat (3) @(negedge clk);
    check_bit("R1 reset out_valid", out_valid, 1'b0);
    check_bit("R1 reset in_ready", in_ready, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check_bit("R1 release out_valid", out_valid, 1'b0);
    check_bit("R1 release in_ready held low", in_ready, 1'b0);
    repeat (2) @(negedge clk);
    check_bit("R1 in_ready after sync", in_ready, 1'b1);

    // R3: first beat uses the all-empty layout; its field carries forward.
    send(mk(2'b00, 2'b00, 2'b00, 2'b00, 2'b00), 1'b0, "R3 first beat empty");
    send(mk(2'b01, 2'b01, 2'b01, 2'b01, 2'b01), 1'b0, "R4 five 26-bit ops len 18");
    send(mk(2'b10, 2'b11, 2'b11, 2'b11, 2'b11), 1'b0, "R2 five 34-bit ops len 23");
    send(mk(2'b11, 2'b11, 2'b11, 2'b11, 2'b10), 1'b0, "R2 slot0 42-bit only len 7");
    send(mk(2'b00, 2'b01, 2'b10, 2'b11, 2'b11), 1'b0, "R10 slot4 only 42-bit");
    send(mk(2'b10, 2'b00, 2'b01, 2'b11, 2'b00), 1'b0, "R5 three mixed ops no extra byte");
    send(mk(2'b11, 2'b11, 2'b11, 2'b11, 2'b11), 1'b0, "R6 four ops extension offsets");
    send(mk(2'b01, 2'b10, 2'b11, 2'b00, 2'b01), 1'b0, "R8 all empty count 0");
    // R7: branch target ignores the held field but keeps its own.
    send(mk(2'b10, 2'b10, 2'b11, 2'b11, 2'b11), 1'b1, "R7 branch target ignores held field");
    send(mk(2'b00, 2'b11, 2'b11, 2'b11, 2'b11), 1'b0, "R7 field from branch beat carried");
    send(mk(2'b11, 2'b11, 2'b11, 2'b11, 2'b11), 1'b1, "R7 back-to-back branch target");
    send(mk(2'b11, 2'b11, 2'b11, 2'b11, 2'b11), 1'b0, "R3 field after branch beat");

    // Random traffic with consumer stalls.
    stall_mode = 1'b1;
    for (int k = 0; k < 300; k++) begin
      rf = 10'($urandom);
      rb = (($urandom % 8) == 0);
      send(rf, rb, rb ? "R7 random branch" : "R4 random layout");
    end
    stall_mode = 1'b0;

    for (int w = 0; w < 50 && exp_q.size() != 0; w++) @(negedge clk);
    n_checks++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R9 results lost: got %0d pending expected 0", exp_q.size());
    end
    done = 1'b1;
    finish_run();
  end

endmodule